// File: doc/BRIEF.md
# Speculative Load Address Prediction Unit

This unit sits in front of a data cache and lets a load or store begin its cache read before the effective address is fully known. A request brings a base register value and a signed 16-bit immediate. In the same cycle, the unit ORs the base with the sign-extended offset and uses the set-index bits of that result to start a cache read. The tag bits are taken from the exact sum.

While the read is in flight, a full adder forms the true effective address. A separate check then decides whether the guessed index was right. The check only steers what happens after the read has started, so it stays off the path into the cache. If the guess was right, the data returns one cycle after the request with no added delay. If it was wrong, the unit repeats the read on the next cycle with the correct index and lowers `req_ready` for that cycle. The response then carries a replay flag, so the pipeline can account for the extra cycle.

Two saturating counters record how many requests were accepted and how many of them needed a replay.

Top module: `fap_unit`

## Requirements
- R1: In the cycle a request is accepted, `cache_rd_en` is high and `cache_index` equals bits [BLK_W+IDX_W-1:BLK_W] of `req_base | sext(req_off)`. The offset is sign-extended from bit 15.
- R2: When the guessed index equals the index bits of the exact sum, the response appears exactly one cycle after acceptance with `resp_replay` = 0.
- R3: When the guessed index is wrong, the cycle after acceptance has `cache_rd_en` = 1 with `cache_index` set to the index bits of the exact sum, `req_ready` = 0 and no response. The response follows one cycle later with `resp_replay` = 1.
- R4: `resp_addr` equals `req_base + sext(req_off)` modulo 2^ADDR_W, and `resp_data` is the cache word read for that address's line.
- R5: A replay occurs exactly when the index field of the OR result differs from the index field of the sum. This includes the case of all-ones fields with a carry coming in from below, which needs no replay.
- R6: `cache_tag` always carries bits [ADDR_W-1:BLK_W+IDX_W] of the exact sum of the request being read.
- R7: `stat_access` counts accepted requests and `stat_mispredict` counts replays. Each is CNT_W bits wide and holds at all-ones instead of wrapping.
- R8: After reset, `req_ready` = 1, `cache_rd_en` = 0 when no request is valid, `resp_valid` = 0, and both counters are zero.
- R9: A request offered while `req_ready` is low is neither read nor counted, and it does not change `cache_index` during the replay cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_base | input | ADDR_W | Base register value |
| req_off | input | OFF_W | Signed immediate offset |
| cache_rd_en | output | 1 | Cache read strobe |
| cache_index | output | IDX_W | Set index for the read |
| cache_tag | output | TAG_W | Tag bits of the exact address |
| cache_rdata | input | DATA_W | Cache data, valid one cycle after the read |
| resp_valid | output | 1 | Response valid |
| resp_addr | output | ADDR_W | Exact effective address |
| resp_data | output | DATA_W | Loaded data |
| resp_replay | output | 1 | Response needed a corrective re-read |
| stat_access | output | CNT_W | Saturating count of accepted requests |
| stat_mispredict | output | CNT_W | Saturating count of replays |

## Verification
The assertions assume two things about the neighbours. The cache must return data exactly one cycle after each read strobe. A requester whose request is refused must keep offering it until `req_ready` is high. The bench models the cache as a one-cycle registered lookup keyed on tag and index. It presents every request at a falling edge, after `req_ready` has been seen high. During a replay cycle it deliberately offers a different request and then withdraws it before `req_ready` returns. The stimulus combines a directed table with random pairs. The table covers carries into the index field, negative offsets, address wrap and the all-ones field corner. The random pairs are numerous enough to drive both counters into saturation.

// File: rtl/fap_pkg.sv
package fap_pkg;
   typedef enum logic [0:0] {
      CHK_COMPARE = 1'b0,
      CHK_CARRY   = 1'b1
   } chk_mode_e;
endpackage

// File: rtl/fap_or_pred.sv
module fap_or_pred #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int BLK_W  = 5,
   parameter int IDX_W  = 7
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] off_x,
   output logic [IDX_W-1:0]  guess_idx
);
   localparam int EXT_W = ADDR_W - OFF_W;
   logic [ADDR_W-1:0] ored;

   generate
      if (EXT_W > 0) begin : g_ext
         assign off_x = {{EXT_W{off[OFF_W-1]}}, off};
      end else begin : g_noext
         assign off_x = off[ADDR_W-1:0];
      end
   endgenerate

   // The single gate level ahead of the cache index.
   assign ored      = base | off_x;
   assign guess_idx = ored[BLK_W +: IDX_W];
endmodule

// File: rtl/fap_sum_check.sv
module fap_sum_check
   import fap_pkg::*;
#(
   parameter int        ADDR_W = 32,
   parameter int        BLK_W  = 5,
   parameter int        IDX_W  = 7,
   parameter chk_mode_e MODE   = CHK_CARRY
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] off_x,
   input  logic [IDX_W-1:0]  guess_idx,
   output logic [ADDR_W-1:0] sum,
   output logic              wrong
);
   assign sum = base + off_x;

   generate
      if (MODE == CHK_COMPARE) begin : g_cmp
         assign wrong = (guess_idx != sum[BLK_W +: IDX_W]);
      end else begin : g_carry
         logic [BLK_W:0]   low;
         logic [IDX_W-1:0] both;
         logic             cin;
         assign low  = {1'b0, base[BLK_W-1:0]} + {1'b0, off_x[BLK_W-1:0]};
         assign cin  = low[BLK_W];
         assign both = base[BLK_W +: IDX_W] & off_x[BLK_W +: IDX_W];
         // A carry into an all-ones field wraps back to the same field value.
         assign wrong = ((|both) | cin) & ~((&both) & cin);
      end
   endgenerate
endmodule

// File: rtl/fap_sat_count.sv
module fap_sat_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (inc && (cnt != {CNT_W{1'b1}}))
         cnt <= cnt + 1'b1;
   end

   p_no_overflow_r7 : assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/fap_unit.sv
module fap_unit
   import fap_pkg::*;
#(
   parameter int        ADDR_W = 32,
   parameter int        OFF_W  = 16,
   parameter int        BLK_W  = 5,
   parameter int        IDX_W  = 7,
   parameter int        DATA_W = 32,
   parameter int        CNT_W  = 32,
   parameter chk_mode_e MODE   = CHK_CARRY,
   localparam int       TAG_W  = ADDR_W - BLK_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [OFF_W-1:0]  req_off,
   output logic              cache_rd_en,
   output logic [IDX_W-1:0]  cache_index,
   output logic [TAG_W-1:0]  cache_tag,
   input  logic [DATA_W-1:0] cache_rdata,
   output logic              resp_valid,
   output logic [ADDR_W-1:0] resp_addr,
   output logic [DATA_W-1:0] resp_data,
   output logic              resp_replay,
   output logic [CNT_W-1:0]  stat_access,
   output logic [CNT_W-1:0]  stat_mispredict
);
   localparam int HI = BLK_W + IDX_W;

   generate
      if (IDX_W < 1 || BLK_W < 1 || HI >= ADDR_W || OFF_W > ADDR_W || CNT_W < 2) begin : g_bad
         $error("fap_unit: inconsistent width parameters");
      end
   endgenerate

   logic [ADDR_W-1:0] off_x, sum, sum_q;
   logic [IDX_W-1:0]  guess_idx;
   logic              wrong, accept;
   logic              replay_q, hit_q, fix_q;

   fap_or_pred #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_pred (
      .base(req_base), .off(req_off), .off_x(off_x), .guess_idx(guess_idx));

   fap_sum_check #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .MODE(MODE)) u_chk (
      .base(req_base), .off_x(off_x), .guess_idx(guess_idx), .sum(sum), .wrong(wrong));

   assign req_ready = ~replay_q;
   assign accept    = req_valid & ~replay_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         replay_q <= 1'b0;
         hit_q    <= 1'b0;
         fix_q    <= 1'b0;
         sum_q    <= '0;
      end else begin
         replay_q <= accept & wrong;
         hit_q    <= accept & ~wrong;
         fix_q    <= replay_q;
         if (accept) sum_q <= sum;
      end
   end

   assign cache_rd_en = accept | replay_q;
   assign cache_index = replay_q ? sum_q[BLK_W +: IDX_W] : guess_idx;
   assign cache_tag   = replay_q ? sum_q[ADDR_W-1:HI] : sum[ADDR_W-1:HI];

   assign resp_valid  = hit_q | fix_q;
   assign resp_replay = fix_q;
   assign resp_addr   = sum_q;
   assign resp_data   = cache_rdata;

   logic [1:0]       inc;
   logic [CNT_W-1:0] cnt [2];
   assign inc = {accept & wrong, accept};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_stat
         fap_sat_count #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .inc(inc[i]), .cnt(cnt[i]));
      end
   endgenerate

   assign stat_access     = cnt[0];
   assign stat_mispredict = cnt[1];

   p_guess_r5 : assert property (@(posedge clk) disable iff (rst)
      accept |-> (wrong == (guess_idx != sum[BLK_W +: IDX_W])));
   p_hit_r2 : assert property (@(posedge clk) disable iff (rst)
      (accept && !wrong) |=> (resp_valid && !resp_replay && resp_addr == $past(sum)));
   p_reread_r3 : assert property (@(posedge clk) disable iff (rst)
      (accept && wrong) |=> (cache_rd_en && !req_ready && !resp_valid
                             && cache_index == $past(sum[BLK_W +: IDX_W])));
   p_replay_resp_r3 : assert property (@(posedge clk) disable iff (rst)
      (cache_rd_en && !req_ready) |=> (resp_valid && resp_replay));
endmodule

// File: tb/fap_unit_bench.sv
`timescale 1ns/1ps
module fap_unit_bench;
   localparam int AW = 32, OW = 16, BW = 5, IW = 7, DW = 32, CW = 6;
   localparam int TW = AW - BW - IW;
   localparam logic [CW-1:0] SAT = '1;

   logic clk = 1'b0, rst = 1'b1;
   logic req_valid = 1'b0, req_ready;
   logic [AW-1:0] req_base = '0;
   logic [OW-1:0] req_off = '0;
   logic cache_rd_en;
   logic [IW-1:0] cache_index;
   logic [TW-1:0] cache_tag;
   logic [DW-1:0] cache_rdata = '0;
   logic resp_valid, resp_replay;
   logic [AW-1:0] resp_addr;
   logic [DW-1:0] resp_data;
   logic [CW-1:0] stat_access, stat_mispredict;

   int checks = 0, fails = 0, n_acc = 0, n_miss = 0;

   always #2.5 clk = ~clk;

   fap_unit #(.ADDR_W(AW), .OFF_W(OW), .BLK_W(BW), .IDX_W(IW), .DATA_W(DW), .CNT_W(CW)) u_fap_unit (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_base(req_base), .req_off(req_off), .cache_rd_en(cache_rd_en),
      .cache_index(cache_index), .cache_tag(cache_tag), .cache_rdata(cache_rdata),
      .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_data(resp_data),
      .resp_replay(resp_replay), .stat_access(stat_access), .stat_mispredict(stat_mispredict));

   function automatic logic [DW-1:0] line_word(logic [AW-BW-1:0] line);
      return ({5'd0, line} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   // One-cycle cache model.
   always @(posedge clk)
      if (cache_rd_en) cache_rdata <= line_word({cache_tag, cache_index});

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] sx(logic [OW-1:0] o);
      return {{(AW-OW){o[OW-1]}}, o};
   endfunction

   task automatic do_req(input logic [AW-1:0] b, input logic [OW-1:0] o);
      logic [AW-1:0] s, g;
      bit miss;
      s = b + sx(o);
      g = b | sx(o);
      miss = (g[BW +: IW] != s[BW +: IW]);
      @(negedge clk);
      req_valid = 1'b1; req_base = b; req_off = o;
      #1;
      chk(req_ready, "R9 ready before offer", {63'd0, req_ready}, 64'd1);
      chk(cache_rd_en && cache_index == g[BW +: IW], "R1 guessed index",
          {56'd0, cache_rd_en, cache_index}, {56'd0, 1'b1, g[BW +: IW]});
      chk(cache_tag == s[AW-1:BW+IW], "R6 tag on first read", {44'd0, cache_tag}, {44'd0, s[AW-1:BW+IW]});
      n_acc++;
      @(negedge clk);
      if (miss) begin
         n_miss++;
         chk(cache_rd_en && !req_ready && !resp_valid, "R3 replay cycle controls",
             {61'd0, cache_rd_en, req_ready, resp_valid}, 64'd4);
         chk(cache_index == s[BW +: IW], "R3 replay index", {57'd0, cache_index}, {57'd0, s[BW +: IW]});
         chk(cache_tag == s[AW-1:BW+IW], "R6 tag on replay", {44'd0, cache_tag}, {44'd0, s[AW-1:BW+IW]});
         req_base = ~b; req_off = ~o;
         #1;
         chk(cache_index == s[BW +: IW], "R9 offer ignored in replay", {57'd0, cache_index}, {57'd0, s[BW +: IW]});
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(resp_valid && (resp_replay == miss), "R5 replay flag",
          {62'd0, resp_valid, resp_replay}, {62'd0, 1'b1, miss});
      chk(resp_addr == s, "R4 address", {32'd0, resp_addr}, {32'd0, s});
      chk(resp_data == line_word(s[AW-1:BW]), miss ? "R3 data" : "R2 data",
          {32'd0, resp_data}, {32'd0, line_word(s[AW-1:BW])});
   endtask

   function automatic logic [CW-1:0] sat(int n);
      return (n > int'(SAT)) ? SAT : CW'(n);
   endfunction

   localparam int NV = 10;
   localparam logic [47:0] VEC [NV] = '{
      {32'h1000_0000, 16'h0004}, {32'h0000_0020, 16'h0020},
      {32'h0000_001F, 16'h0001}, {32'h0000_0FFF, 16'h0FE1},
      {32'h0000_1000, 16'hFFFC}, {32'h8000_0040, 16'h8000},
      {32'hFFFF_FFE0, 16'h0020}, {32'h1234_5600, 16'h0013},
      {32'h0000_0000, 16'h0000}, {32'h0000_0400, 16'h0400}};

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready && !cache_rd_en && !resp_valid, "R8 reset outputs",
          {61'd0, req_ready, cache_rd_en, resp_valid}, 64'd4);
      rst = 1'b0;
      @(negedge clk);
      chk(stat_access == 0 && stat_mispredict == 0, "R8 counters zero",
          {52'd0, stat_access, stat_mispredict}, 64'd0);
      for (int i = 0; i < NV; i++) do_req(VEC[i][47:16], VEC[i][15:0]);
      // All-ones field with carry in: no replay (R5 corner, vector 3).
      @(negedge clk);
      chk(stat_access == sat(n_acc), "R7 access count", {58'd0, stat_access}, {58'd0, sat(n_acc)});
      chk(stat_mispredict == sat(n_miss), "R7 replay count", {58'd0, stat_mispredict}, {58'd0, sat(n_miss)});
      for (int i = 0; i < 70; i++) begin
         logic [AW-1:0] b;
         logic [OW-1:0] o;
         b = $urandom;
         o = 16'($urandom);
         if (i % 3 == 0) o[BW+IW-1:BW] = b[BW+IW-1:BW];
         do_req(b, o);
      end
      @(negedge clk);
      chk(stat_access == sat(n_acc), "R7 access saturates", {58'd0, stat_access}, {58'd0, sat(n_acc)});
      chk(stat_mispredict == sat(n_miss), "R7 replay count final", {58'd0, stat_mispredict}, {58'd0, sat(n_miss)});
      chk(!resp_valid && req_ready, "R8 idle after traffic", {62'd0, resp_valid, req_ready}, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule